// File: doc/BRIEF.md
# Branch Decision and Next-Location Unit

This block sits in the execute stage of a 16-bit processor whose 24-bit address space is split into a 16-bit program counter and an 8-bit bank register. For each branch or jump the decoder presents, it decides whether control is transferred. It then produces the next program counter, the next bank and the number of machine cycles the instruction costs.

The decoder presents a 5-bit class code together with the flags (zero, carry, negative, overflow and a dedicated test flag), an 8-bit signed displacement, the current counter and bank, and a 32-bit operand. The operand carries the accumulator, a register pair or a fetched target. A request is marked by `req_valid`. The result appears registered one cycle later, marked by `res_valid`, and is held until the next request. Fetching, operand reads and stack writes for calls are handled elsewhere.

Class codes 0 to 15 are conditional relative branches. The codes form eight pairs: the even code branches when its condition is 1, and the odd code branches when that condition is 0. Code 16 is the unconditional relative branch. Codes 17 to 20 are jumps. Codes 21 to 31 are reserved.

Top module: `branch_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first request, `res_valid`, `res_taken`, `next_pc`, `next_bank` and `res_cycles` are all zero.
- R2: `res_valid` is high in exactly the cycles that follow a cycle in which `req_valid` was high.
- R3: Codes 0/1 test Z, codes 2/3 test C, codes 4/5 test N, codes 6/7 test V and codes 8/9 test T. The even code of each pair branches when its flag is 1, and the odd code branches when its flag is 0.
- R4: Code 10 branches when N xor V is 1, and code 11 when it is 0. Code 12 branches when (N xor V) or Z is 1, and code 13 when it is 0.
- R5: Code 14 branches when C or Z is 1, and code 15 when it is 0.
- R6: A taken relative branch (codes 0 to 16, where code 16 is always taken) sets `next_pc` to `pc_in` + 2 + the sign-extended `disp`, modulo 2^16. It leaves `next_bank` equal to `bank_in`.
- R7: An untaken conditional branch gives `res_taken` = 0, `next_pc` = `pc_in` + 2 modulo 2^16, and `next_bank` = `bank_in`.
- R8: Codes 0 to 16 report 4 cycles when taken and 3 cycles when not taken.
- R9: Code 17 (jump through the accumulator) is taken, loads `next_pc` from `operand[15:0]`, keeps the bank and reports 2 cycles.
- R10: Code 18 (absolute 16-bit jump) is taken, loads `next_pc` from `operand[15:0]`, keeps the bank and reports 3 cycles.
- R11: Code 19 (absolute 24-bit jump) is taken, loads `next_pc` from `operand[15:0]` and `next_bank` from `operand[23:16]`, and reports 4 cycles.
- R12: Code 20 (far jump through a register pair) is taken. It loads `next_pc` from the first word `operand[15:0]` and `next_bank` from the low byte of the second word, `operand[23:16]`, and reports 5 cycles.
- R13: Codes 21 to 31 behave as an untaken branch: `res_taken` = 0, `next_pc` = `pc_in` + 2, the bank is kept, and 3 cycles are reported.
- R14: In a cycle without a request, all result outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A branch/jump class is presented this cycle |
| op | input | 5 | Class code |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| flag_t | input | 1 | Test flag |
| disp | input | 8 | Signed relative displacement |
| pc_in | input | 16 | Counter of the current instruction |
| bank_in | input | 8 | Current bank register |
| operand | input | 32 | Accumulator, register pair or fetched target |
| res_valid | output | 1 | Result registered from the previous cycle's request |
| res_taken | output | 1 | Control is transferred |
| next_pc | output | 16 | Next program counter |
| next_bank | output | 8 | Next bank register |
| res_cycles | output | 3 | Machine cycles of the instruction |

## Verification
A taken relative branch decides its condition and, in the same cycle, computes an offset that may carry out of the 16-bit counter. Directed cases provoke this by placing `pc_in` near 0xFFFF with a positive displacement, and near 0x0000 with a negative one. The bench judges that the counter wraps and that `next_bank` still equals `bank_in` with no carry into the bank. Random requests, mixed with idle cycles, are compared against a bench model on the cycle after each request.

// File: rtl/branch_unit.sv
module branch_unit #(
  parameter int PC_W   = 16,
  parameter int BANK_W = 8,
  parameter int DISP_W = 8,
  parameter int ILEN   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [4:0]        op,
  input  logic              flag_z,
  input  logic              flag_c,
  input  logic              flag_n,
  input  logic              flag_v,
  input  logic              flag_t,
  input  logic [DISP_W-1:0] disp,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [BANK_W-1:0] bank_in,
  input  logic [31:0]       operand,
  output logic              res_valid,
  output logic              res_taken,
  output logic [PC_W-1:0]   next_pc,
  output logic [BANK_W-1:0] next_bank,
  output logic [2:0]        res_cycles
);
  localparam int EXT_W = PC_W - DISP_W;

  logic            base, cond_hit, is_rel;
  logic [PC_W-1:0] seq_pc, rel_pc;
  logic            d_taken;
  logic [PC_W-1:0] d_pc;
  logic [BANK_W-1:0] d_bank;
  logic [2:0]      d_cycles;

  always_comb begin
    unique case (op[3:1])
      3'd0: base = flag_z;
      3'd1: base = flag_c;
      3'd2: base = flag_n;
      3'd3: base = flag_v;
      3'd4: base = flag_t;
      3'd5: base = flag_n ^ flag_v;
      3'd6: base = (flag_n ^ flag_v) | flag_z;
      default: base = flag_c | flag_z;
    endcase
  end

  assign cond_hit = base ^ op[0];
  assign is_rel   = (op <= 5'd16);
  assign seq_pc   = pc_in + PC_W'(ILEN);
  assign rel_pc   = seq_pc + {{EXT_W{disp[DISP_W-1]}}, disp};

  always_comb begin
    d_taken  = 1'b0;
    d_pc     = seq_pc;
    d_bank   = bank_in;
    d_cycles = 3'd3;
    if (is_rel) begin
      d_taken  = op[4] | cond_hit;
      d_pc     = d_taken ? rel_pc : seq_pc;
      d_cycles = d_taken ? 3'd4 : 3'd3;
    end else begin
      case (op)
        5'd17: begin d_taken = 1'b1; d_pc = operand[PC_W-1:0]; d_cycles = 3'd2; end
        5'd18: begin d_taken = 1'b1; d_pc = operand[PC_W-1:0]; d_cycles = 3'd3; end
        5'd19: begin
          d_taken = 1'b1; d_pc = operand[PC_W-1:0];
          d_bank = operand[PC_W +: BANK_W]; d_cycles = 3'd4;
        end
        5'd20: begin
          d_taken = 1'b1; d_pc = operand[PC_W-1:0];
          d_bank = operand[PC_W +: BANK_W]; d_cycles = 3'd5;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_taken  <= 1'b0;
      next_pc    <= '0;
      next_bank  <= '0;
      res_cycles <= '0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_taken  <= d_taken;
        next_pc    <= d_pc;
        next_bank  <= d_bank;
        res_cycles <= d_cycles;
      end
    end
  end
endmodule

// File: rtl/branch_unit_chk.sv
module branch_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [4:0]  op,
  input logic [15:0] pc_in,
  input logic [7:0]  bank_in,
  input logic [31:0] operand,
  input logic        res_valid,
  input logic        res_taken,
  input logic [15:0] next_pc,
  input logic [7:0]  next_bank,
  input logic [2:0]  res_cycles
);
  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid);
  assert_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(next_pc) && $stable(next_bank) && $stable(res_cycles) && $stable(res_taken)));
  assert_untaken_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (res_taken || next_pc == $past(pc_in) + 16'd2));
  assert_rel_cycles_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op <= 5'd16) |=> (res_cycles == (res_taken ? 3'd4 : 3'd3)));
  assert_near_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op <= 5'd18) |=> (next_bank == $past(bank_in)));
  assert_far_bank_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (op == 5'd19 || op == 5'd20)) |=> (res_taken && next_bank == $past(operand[23:16])));
  assert_reserved_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op >= 5'd21) |=> (!res_taken && res_cycles == 3'd3));
endmodule

bind branch_unit branch_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op(op),
  .pc_in(pc_in), .bank_in(bank_in), .operand(operand),
  .res_valid(res_valid), .res_taken(res_taken), .next_pc(next_pc),
  .next_bank(next_bank), .res_cycles(res_cycles)
);

// File: tb/branch_unit_tb.sv
module branch_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [4:0] op = '0;
  logic fz = 0, fc = 0, fn = 0, fv = 0, ft = 0;
  logic [7:0] disp = '0;
  logic [15:0] pc_in = '0;
  logic [7:0] bank_in = '0;
  logic [31:0] operand = '0;
  logic res_valid, res_taken;
  logic [15:0] next_pc;
  logic [7:0] next_bank;
  logic [2:0] res_cycles;

  int vecs = 0, errs = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  branch_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op(op),
    .flag_z(fz), .flag_c(fc), .flag_n(fn), .flag_v(fv), .flag_t(ft),
    .disp(disp), .pc_in(pc_in), .bank_in(bank_in), .operand(operand),
    .res_valid(res_valid), .res_taken(res_taken), .next_pc(next_pc),
    .next_bank(next_bank), .res_cycles(res_cycles)
  );

  function automatic bit cond_of(input logic [4:0] o, input bit z, c, n, v, t);
    case (o)
      0: return z;          1: return !z;
      2: return c;          3: return !c;
      4: return n;          5: return !n;
      6: return v;          7: return !v;
      8: return t;          9: return !t;
      10: return n != v;    11: return n == v;
      12: return (n != v) || z;  13: return !((n != v) || z);
      14: return c || z;    15: return !(c || z);
      16: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input logic [4:0] o);
    if (o <= 9) return "R3";
    if (o <= 13) return "R4";
    if (o <= 15) return "R5";
    if (o == 16) return "R6";
    if (o == 17) return "R9";
    if (o == 18) return "R10";
    if (o == 19) return "R11";
    if (o == 20) return "R12";
    return "R13";
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  task automatic apply(input logic [4:0] o, input bit z, c, n, v, t,
                       input logic [7:0] d, input logic [15:0] p,
                       input logic [7:0] b, input logic [31:0] opd);
    bit tk;
    logic [15:0] epc;
    logic [7:0] ebank;
    int ecyc;
    string tg;
    op = o; fz = z; fc = c; fn = n; fv = v; ft = t;
    disp = d; pc_in = p; bank_in = b; operand = opd; req_valid = 1;
    tg = tag_of(o);
    ebank = b;
    if (o <= 16) begin
      tk = cond_of(o, z, c, n, v, t);
      epc = tk ? 16'(p + 16'd2 + {{8{d[7]}}, d}) : 16'(p + 16'd2);
      ecyc = tk ? 4 : 3;
    end else if (o <= 20) begin
      tk = 1; epc = opd[15:0];
      ecyc = (o == 17) ? 2 : (o == 18) ? 3 : (o == 19) ? 4 : 5;
      if (o >= 19) ebank = opd[23:16];
    end else begin
      tk = 0; epc = 16'(p + 16'd2); ecyc = 3;
    end
    @(negedge clk);
    req_valid = 0;
    check("R2", "res_valid", int'(res_valid), 1);
    check(tg, "taken", int'(res_taken), int'(tk));
    check((o <= 16 && tk) ? "R6" : (o <= 16 ? "R7" : tg), "next_pc", int'(next_pc), int'(epc));
    check(o <= 16 ? "R6" : tg, "next_bank", int'(next_bank), int'(ebank));
    check(o <= 16 ? "R8" : tg, "cycles", int'(res_cycles), ecyc);
  endtask

  task automatic idle_check();
    logic [15:0] hp = next_pc;
    logic [7:0] hb = next_bank;
    logic [2:0] hc = res_cycles;
    logic ht = res_taken;
    op = 5'd17; operand = 32'hFFFF_FFFF; pc_in = 16'h1234;
    @(negedge clk);
    check("R2", "idle res_valid", int'(res_valid), 0);
    check("R14", "hold pc", int'(next_pc), int'(hp));
    check("R14", "hold bank", int'(next_bank), int'(hb));
    check("R14", "hold cycles", int'(res_cycles), int'(hc));
    check("R14", "hold taken", int'(res_taken), int'(ht));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errs++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd1977));
    repeat (3) @(negedge clk);
    check("R1", "reset valid", int'(res_valid), 0);
    check("R1", "reset taken", int'(res_taken), 0);
    check("R1", "reset pc", int'(next_pc), 0);
    check("R1", "reset bank", int'(next_bank), 0);
    check("R1", "reset cycles", int'(res_cycles), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1", "post-reset pc", int'(next_pc), 0);

    for (int o = 0; o < 32; o++) begin
      apply(5'(o), 0, 0, 0, 0, 0, 8'h10, 16'h4000, 8'h3C, 32'h00A5_1234);
      apply(5'(o), 1, 1, 1, 1, 1, 8'hF0, 16'h4000, 8'h3C, 32'h005A_4321);
    end
    apply(5'd10, 0, 0, 1, 0, 0, 8'h04, 16'h0100, 8'h01, 0);
    apply(5'd11, 0, 0, 1, 1, 0, 8'h04, 16'h0100, 8'h01, 0);
    apply(5'd12, 1, 0, 0, 0, 0, 8'h04, 16'h0100, 8'h01, 0);
    apply(5'd13, 0, 0, 1, 0, 0, 8'h04, 16'h0100, 8'h01, 0);
    apply(5'd14, 0, 1, 0, 0, 0, 8'h04, 16'h0100, 8'h01, 0);
    apply(5'd15, 1, 0, 0, 0, 0, 8'h04, 16'h0100, 8'h01, 0);
    apply(5'd16, 0, 0, 0, 0, 0, 8'h05, 16'hFFFE, 8'h7F, 0);
    apply(5'd0, 1, 0, 0, 0, 0, 8'h80, 16'h0001, 8'hFF, 0);
    apply(5'd1, 1, 0, 0, 0, 0, 8'h00, 16'hFFFF, 8'hFF, 0);
    apply(5'd20, 0, 0, 0, 0, 0, 0, 16'h2222, 8'h11, 32'h77EE_BEEF);
    idle_check();
    idle_check();

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r = $urandom;
      apply(5'($urandom % 32), r[0], r[1], r[2], r[3], r[4],
            8'($urandom), 16'($urandom), 8'($urandom), $urandom);
      if (r[7:5] == 3'd0) idle_check();
    end
    finish_run();
  end
endmodule